// File: doc/BRIEF.md
# Multi-level bus breakpoint sequencer

This block watches a processor bus one cycle at a time and compares each completed cycle against up to four programmable conditions. Each condition covers an address under a mask, a data value under a mask and a cycle kind. The conditions form a chain. Only the condition of the current level is watched. When it has been met the required number of times, the next level becomes the one watched. When the last level in use is satisfied, the block either raises a sticky halt request to the processor or emits a one-cycle trace-start pulse, so the program need not stop.

The comparison runs alongside the bus and never holds it up. Two further break sources feed the same halt request:
- An execution-address breakpoint. It compares the address of instructions that actually retired, taken from a separate qualifier port, so program memory is never patched and ROM code can be stopped. An instruction fetched ahead and then thrown away after a jump, call or interrupt never reaches the retire port and cannot break.
- A bus-hang detector. It halts when a bus cycle stays open longer than a programmed number of clocks.

A small synchronous write port loads all settings. A clear input returns the chain to level 0 and drops any pending halt.

Top module: `bus_break_seq`

## Requirements
- R1: While rst_n is low, and in the cycle after seq_clear is sampled high, halt_req and trace_trig are 0 and seq_level is 0. seq_clear overrides every break source sampled in the same cycle.
- R2: A level's condition holds for a cycle with bus_valid high when ((bus_addr xor addr value) and addr mask) is zero, ((bus_data xor data value) and data mask) is zero, and the level's kind matches bus_type. Kind encoding is 0 read, 1 write, 2 fetch, 3 any. A mask bit of 1 means the bit is compared.
- R3: Only the condition of level seq_level is evaluated. A cycle that would satisfy a later level has no effect. Satisfying level k moves seq_level to k+1 in the next cycle. Satisfying the last level in use (the control field) returns seq_level to 0.
- R4: Each level has a pass count N (0 is taken as 1). The level is satisfied on the N-th matching cycle counted since the level was entered. Non-matching cycles in between neither count nor reset the tally.
- R5: When the last level is satisfied at a clock edge, the action shows from that edge on. With control bit 0 clear, halt_req rises and stays high until seq_clear. With the bit set, trace_trig is high for exactly that one cycle and halt_req is untouched.
- R6: With control bit 4 set, a cycle with exec_valid high and exec_addr equal to the execution breakpoint register sets halt_req in the next cycle. A bus fetch of that address without exec_valid has no effect.
- R7: With control bit 5 set, halt_req is set at the edge ending the (L+1)-th consecutive cycle of bus_open high, where L is the hang limit register. A run of L cycles or fewer has no effect.
- R8: With control bit 1 (sequencer enable) clear, bus cycles neither advance seq_level nor fire the final action.
- R9: A cfg_we write stores cfg_wdata at cfg_addr. The address map is as follows.
  - Level k registers sit at cfg_addr = 4k+f, with f chosen as follows.
    - f=0: address value.
    - f=1: address mask.
    - f=2: data value in bits 7:0, data mask in bits 15:8.
    - f=3: kind in bits 1:0, pass count in bits 5:2.
  - Address 16 is control: bit 0 trace action, bit 1 sequencer enable, bits 3:2 last level in use, bit 4 execution break enable, bit 5 hang enable.
  - Address 17 is the execution breakpoint address.
  - Address 18 is the hang limit, bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register index |
| cfg_wdata | input | 16 | Configuration write value |
| bus_valid | input | 1 | A bus cycle completes this clock |
| bus_type | input | 2 | Cycle kind: 0 read, 1 write, 2 fetch |
| bus_addr | input | 16 | Bus cycle address |
| bus_data | input | 8 | Bus cycle data |
| bus_open | input | 1 | A bus cycle is in progress and not yet acknowledged |
| exec_valid | input | 1 | An instruction retired this clock |
| exec_addr | input | 16 | Address of the retired instruction |
| seq_clear | input | 1 | Return chain to level 0 and clear halt |
| halt_req | output | 1 | Sticky halt request to the processor |
| trace_trig | output | 1 | One-cycle trace-start pulse |
| seq_level | output | 2 | Level currently watched |

## Verification
Every result is registered once. A bus cycle, retire or open-cycle sample presented before a rising edge shows on halt_req, trace_trig and seq_level right after that same edge. A configuration write takes effect for bus cycles on the following edge. The bench drives inputs just after a falling edge and samples outputs at the next falling edge, half a period after the edge that acts on them. A bench model updates its expected state at the same edge, so every sample compares one cycle of stimulus against one step of the model. A hang run of L+1 open cycles is therefore checked after the (L+1)-th sample and confirmed low after the L-th.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  typedef enum logic [1:0] {
    BK_READ  = 2'd0,
    BK_WRITE = 2'd1,
    BK_FETCH = 2'd2,
    BK_ANY   = 2'd3
  } bus_kind_e;

  // field selectors inside one level's register group
  localparam logic [1:0] FLD_AVAL  = 2'd0;
  localparam logic [1:0] FLD_AMASK = 2'd1;
  localparam logic [1:0] FLD_DATA  = 2'd2;
  localparam logic [1:0] FLD_KIND  = 2'd3;

  // global registers (upper half of the map)
  localparam logic [1:0] GR_CTRL = 2'd0;
  localparam logic [1:0] GR_EXEC = 2'd1;
  localparam logic [1:0] GR_HANG = 2'd2;
endpackage

// File: rtl/bbs_cfg_regs.sv
module bbs_cfg_regs
  import bbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int LEVELS = 4,
  parameter int CNT_W  = 4,
  parameter int HANG_W = 8,
  localparam int LVL_W = $clog2(LEVELS),
  localparam int CA_W  = LVL_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CA_W-1:0]   cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] lv_aval  [LEVELS],
  output logic [ADDR_W-1:0] lv_amask [LEVELS],
  output logic [DATA_W-1:0] lv_dval  [LEVELS],
  output logic [DATA_W-1:0] lv_dmask [LEVELS],
  output logic [1:0]        lv_kind  [LEVELS],
  output logic [CNT_W-1:0]  lv_need  [LEVELS],
  output logic              act_trace,
  output logic              seq_en,
  output logic [LVL_W-1:0]  last_lvl,
  output logic              exec_en,
  output logic              hang_en,
  output logic [ADDR_W-1:0] exec_bp,
  output logic [HANG_W-1:0] hang_lim
);
  logic             is_glob;
  logic [LVL_W-1:0] sel_lvl;
  logic [1:0]       fld;

  assign is_glob = cfg_addr[CA_W-1];
  assign sel_lvl = cfg_addr[CA_W-2:2];
  assign fld     = cfg_addr[1:0];

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    logic              wr_en;
    logic [ADDR_W-1:0] r_aval, r_amask;
    logic [DATA_W-1:0] r_dval, r_dmask;
    logic [1:0]        r_kind;
    logic [CNT_W-1:0]  r_need;

    assign wr_en = cfg_we && !is_glob && (sel_lvl == LVL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_aval  <= '0;
        r_amask <= '0;
        r_dval  <= '0;
        r_dmask <= '0;
        r_kind  <= BK_READ;
        r_need  <= '0;
      end else if (wr_en) begin
        case (fld)
          FLD_AVAL:  r_aval  <= cfg_wdata;
          FLD_AMASK: r_amask <= cfg_wdata;
          FLD_DATA: begin
            r_dval  <= cfg_wdata[DATA_W-1:0];
            r_dmask <= cfg_wdata[2*DATA_W-1:DATA_W];
          end
          default: begin
            r_kind <= cfg_wdata[1:0];
            r_need <= cfg_wdata[CNT_W+1:2];
          end
        endcase
      end
    end

    assign lv_aval[g]  = r_aval;
    assign lv_amask[g] = r_amask;
    assign lv_dval[g]  = r_dval;
    assign lv_dmask[g] = r_dmask;
    assign lv_kind[g]  = r_kind;
    assign lv_need[g]  = r_need;
  end

  logic ctrl_we, exec_we, hang_we;
  assign ctrl_we = cfg_we && is_glob && (fld == GR_CTRL);
  assign exec_we = cfg_we && is_glob && (fld == GR_EXEC);
  assign hang_we = cfg_we && is_glob && (fld == GR_HANG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_trace <= 1'b0;
      seq_en    <= 1'b0;
      last_lvl  <= '0;
      exec_en   <= 1'b0;
      hang_en   <= 1'b0;
    end else if (ctrl_we) begin
      act_trace <= cfg_wdata[0];
      seq_en    <= cfg_wdata[1];
      last_lvl  <= cfg_wdata[LVL_W+1:2];
      exec_en   <= cfg_wdata[4];
      hang_en   <= cfg_wdata[5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       exec_bp <= '0;
    else if (exec_we) exec_bp <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hang_lim <= '0;
    else if (hang_we) hang_lim <= cfg_wdata[HANG_W-1:0];
  end
endmodule

// File: rtl/bbs_level_match.sv
module bbs_level_match
  import bbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [1:0]        bus_type,
  input  logic [ADDR_W-1:0] aval,
  input  logic [ADDR_W-1:0] amask,
  input  logic [DATA_W-1:0] dval,
  input  logic [DATA_W-1:0] dmask,
  input  logic [1:0]        kind,
  output logic              hit
);
  logic addr_ok, data_ok, kind_ok;

  always_comb begin
    addr_ok = (((bus_addr ^ aval) & amask) == '0);
    data_ok = (((bus_data ^ dval) & dmask) == '0);
    kind_ok = (kind == BK_ANY) || (kind == bus_type);
    hit     = addr_ok && data_ok && kind_ok;
  end
endmodule

// File: rtl/bbs_seq_core.sv
module bbs_seq_core #(
  parameter int LEVELS = 4,
  parameter int CNT_W  = 4,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              enable,
  input  logic              step,
  input  logic [LEVELS-1:0] lvl_hit,
  input  logic [CNT_W-1:0]  lv_need [LEVELS],
  input  logic [LVL_W-1:0]  last_lvl,
  output logic [LVL_W-1:0]  lvl,
  output logic              fire
);
  logic [CNT_W-1:0] occ, occ_nx;
  logic [LVL_W-1:0] lvl_nx;
  logic [CNT_W:0]   need_eff, tally;
  logic             cur_hit, reached;

  always_comb begin
    cur_hit  = lvl_hit[lvl];
    need_eff = (lv_need[lvl] == '0) ? (CNT_W+1)'(1) : {1'b0, lv_need[lvl]};
    tally    = {1'b0, occ} + (CNT_W+1)'(1);
    reached  = (tally >= need_eff);
    lvl_nx   = lvl;
    occ_nx   = occ;
    fire     = 1'b0;
    if (clear) begin
      lvl_nx = '0;
      occ_nx = '0;
    end else if (enable && step && cur_hit) begin
      if (reached) begin
        occ_nx = '0;
        if (lvl == last_lvl) begin
          fire   = 1'b1;
          lvl_nx = '0;
        end else begin
          lvl_nx = lvl + LVL_W'(1);
        end
      end else begin
        occ_nx = occ + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= '0;
      occ <= '0;
    end else begin
      lvl <= lvl_nx;
      occ <= occ_nx;
    end
  end
endmodule

// File: rtl/bbs_hang_timer.sv
module bbs_hang_timer #(
  parameter int HANG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_open,
  input  logic              enable,
  input  logic [HANG_W-1:0] limit,
  output logic              hang_hit
);
  logic [HANG_W-1:0] open_cnt, open_cnt_nx;

  always_comb begin
    if (!bus_open)            open_cnt_nx = '0;
    else if (&open_cnt)       open_cnt_nx = open_cnt;
    else                      open_cnt_nx = open_cnt + HANG_W'(1);
    hang_hit = enable && bus_open && (open_cnt == limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_cnt <= '0;
    else        open_cnt <= open_cnt_nx;
  end
endmodule

// File: rtl/bus_break_seq.sv
module bus_break_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int LEVELS = 4,
  parameter int CNT_W  = 4,
  parameter int HANG_W = 8,
  localparam int LVL_W = $clog2(LEVELS),
  localparam int CA_W  = LVL_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CA_W-1:0]   cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              bus_valid,
  input  logic [1:0]        bus_type,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_open,
  input  logic              exec_valid,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic              seq_clear,
  output logic              halt_req,
  output logic              trace_trig,
  output logic [LVL_W-1:0]  seq_level
);
  logic [ADDR_W-1:0] lv_aval  [LEVELS];
  logic [ADDR_W-1:0] lv_amask [LEVELS];
  logic [DATA_W-1:0] lv_dval  [LEVELS];
  logic [DATA_W-1:0] lv_dmask [LEVELS];
  logic [1:0]        lv_kind  [LEVELS];
  logic [CNT_W-1:0]  lv_need  [LEVELS];
  logic              act_trace, seq_en, exec_en, hang_en;
  logic [LVL_W-1:0]  last_lvl;
  logic [ADDR_W-1:0] exec_bp;
  logic [HANG_W-1:0] hang_lim;
  logic [LEVELS-1:0] lvl_hit;
  logic              fire, hang_hit, exec_hit;
  logic              halt_nx, trig_nx;

  bbs_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEVELS(LEVELS),
    .CNT_W(CNT_W), .HANG_W(HANG_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata),
    .lv_aval(lv_aval), .lv_amask(lv_amask), .lv_dval(lv_dval),
    .lv_dmask(lv_dmask), .lv_kind(lv_kind), .lv_need(lv_need),
    .act_trace(act_trace), .seq_en(seq_en), .last_lvl(last_lvl),
    .exec_en(exec_en), .hang_en(hang_en), .exec_bp(exec_bp),
    .hang_lim(hang_lim)
  );

  for (genvar g = 0; g < LEVELS; g++) begin : g_cmp
    bbs_level_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
      .bus_addr(bus_addr), .bus_data(bus_data), .bus_type(bus_type),
      .aval(lv_aval[g]), .amask(lv_amask[g]), .dval(lv_dval[g]),
      .dmask(lv_dmask[g]), .kind(lv_kind[g]), .hit(lvl_hit[g])
    );
  end

  bbs_seq_core #(.LEVELS(LEVELS), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .clear(seq_clear), .enable(seq_en),
    .step(bus_valid), .lvl_hit(lvl_hit), .lv_need(lv_need),
    .last_lvl(last_lvl), .lvl(seq_level), .fire(fire)
  );

  bbs_hang_timer #(.HANG_W(HANG_W)) u_hang (
    .clk(clk), .rst_n(rst_n), .bus_open(bus_open), .enable(hang_en),
    .limit(hang_lim), .hang_hit(hang_hit)
  );

  // retire-qualified execution breakpoint: discarded prefetches never retire
  assign exec_hit = exec_en && exec_valid && (exec_addr == exec_bp);

  always_comb begin
    if (seq_clear) begin
      halt_nx = 1'b0;
      trig_nx = 1'b0;
    end else begin
      halt_nx = halt_req || (fire && !act_trace) || exec_hit || hang_hit;
      trig_nx = fire && act_trace;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_req   <= 1'b0;
      trace_trig <= 1'b0;
    end else begin
      halt_req   <= halt_nx;
      trace_trig <= trig_nx;
    end
  end
endmodule

// File: rtl/bbs_checker.sv
module bbs_checker #(
  parameter int LVL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             seq_clear,
  input logic             bus_valid,
  input logic             bus_open,
  input logic             exec_valid,
  input logic             act_trace,
  input logic             halt_req,
  input logic             trace_trig,
  input logic [LVL_W-1:0] seq_level
);
  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seq_clear |=> (!halt_req && !trace_trig && seq_level == '0));

  assert_level_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(seq_level) |-> $past(bus_valid || seq_clear));

  assert_level_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_level > $past(seq_level)) |-> (seq_level == $past(seq_level) + LVL_W'(1)));

  assert_halt_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !seq_clear) |=> halt_req);

  assert_trace_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trace_trig |-> $past(act_trace));

  assert_halt_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> $past(bus_valid || exec_valid || bus_open));
endmodule

bind bus_break_seq bbs_checker #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .seq_clear(seq_clear), .bus_valid(bus_valid),
  .bus_open(bus_open), .exec_valid(exec_valid), .act_trace(act_trace),
  .halt_req(halt_req), .trace_trig(trace_trig), .seq_level(seq_level)
);

// File: tb/bus_break_seq_tb.sv
`timescale 1ns/1ps
module bus_break_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        bus_valid;
  logic [1:0]  bus_type;
  logic [15:0] bus_addr;
  logic [7:0]  bus_data;
  logic        bus_open;
  logic        exec_valid;
  logic [15:0] exec_addr;
  logic        seq_clear;
  logic        halt_req, trace_trig;
  logic [1:0]  seq_level;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  bus_break_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_type(bus_type),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_open(bus_open),
    .exec_valid(exec_valid), .exec_addr(exec_addr), .seq_clear(seq_clear),
    .halt_req(halt_req), .trace_trig(trace_trig), .seq_level(seq_level)
  );

  // ---------------- bench model, from the requirements ----------------
  logic [15:0] m_aval [4];
  logic [15:0] m_amask[4];
  logic [7:0]  m_dval [4];
  logic [7:0]  m_dmask[4];
  logic [1:0]  m_kind [4];
  logic [3:0]  m_need [4];
  logic        m_act, m_en, m_xen, m_hen;
  logic [1:0]  m_last;
  logic [15:0] m_xbp;
  logic [7:0]  m_lim;
  logic [1:0]  m_lvl;
  int          m_occ;
  logic        m_halt, m_trig;
  int          m_hcnt;

  function automatic bit m_match(input int k);
    bit a_ok, d_ok, t_ok;
    a_ok = ((bus_addr ^ m_aval[k]) & m_amask[k]) == 16'h0;
    d_ok = ((bus_data ^ m_dval[k]) & m_dmask[k]) == 8'h0;
    t_ok = (m_kind[k] == 2'd3) || (m_kind[k] == bus_type);
    return a_ok && d_ok && t_ok;
  endfunction

  task automatic m_reset();
    for (int k = 0; k < 4; k++) begin
      m_aval[k] = '0; m_amask[k] = '0; m_dval[k] = '0;
      m_dmask[k] = '0; m_kind[k] = '0; m_need[k] = '0;
    end
    m_act = 0; m_en = 0; m_xen = 0; m_hen = 0; m_last = 0;
    m_xbp = 0; m_lim = 0; m_lvl = 0; m_occ = 0;
    m_halt = 0; m_trig = 0; m_hcnt = 0;
  endtask

  task automatic m_edge();
    bit fire = 0;
    bit xh, hh;
    int need;
    hh = m_hen && bus_open && (m_hcnt == int'(m_lim));
    xh = m_xen && exec_valid && (exec_addr == m_xbp);
    if (seq_clear) begin
      m_lvl = 0; m_occ = 0; m_halt = 0; m_trig = 0;
    end else begin
      if (m_en && bus_valid && m_match(int'(m_lvl))) begin
        need = (m_need[m_lvl] == 0) ? 1 : int'(m_need[m_lvl]);
        if (m_occ + 1 >= need) begin
          m_occ = 0;
          if (m_lvl == m_last) begin fire = 1; m_lvl = 0; end
          else m_lvl = m_lvl + 2'd1;
        end else m_occ = m_occ + 1;
      end
      m_halt = m_halt | (fire & !m_act) | xh | hh;
      m_trig = fire & m_act;
    end
    if (!bus_open) m_hcnt = 0;
    else if (m_hcnt < 255) m_hcnt = m_hcnt + 1;
    if (cfg_we) begin
      if (!cfg_addr[4]) begin
        case (cfg_addr[1:0])
          2'd0: m_aval[cfg_addr[3:2]]  = cfg_wdata;
          2'd1: m_amask[cfg_addr[3:2]] = cfg_wdata;
          2'd2: begin
            m_dval[cfg_addr[3:2]]  = cfg_wdata[7:0];
            m_dmask[cfg_addr[3:2]] = cfg_wdata[15:8];
          end
          default: begin
            m_kind[cfg_addr[3:2]] = cfg_wdata[1:0];
            m_need[cfg_addr[3:2]] = cfg_wdata[5:2];
          end
        endcase
      end else begin
        case (cfg_addr[1:0])
          2'd0: begin
            m_act = cfg_wdata[0]; m_en = cfg_wdata[1]; m_last = cfg_wdata[3:2];
            m_xen = cfg_wdata[4]; m_hen = cfg_wdata[5];
          end
          2'd1: m_xbp = cfg_wdata;
          2'd2: m_lim = cfg_wdata[7:0];
          default: ;
        endcase
      end
    end
  endtask

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) m_edge();
    @(negedge clk);
    chk({cur_req, " outputs vs model"},
        {13'd0, halt_req, trace_trig, 1'b0} | {14'd0, seq_level},
        {13'd0, m_halt, m_trig, 1'b0} | {14'd0, m_lvl});
  endtask

  task automatic idle_in();
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; bus_valid = 0; bus_type = 0;
    bus_addr = 0; bus_data = 0; bus_open = 0; exec_valid = 0; exec_addr = 0;
    seq_clear = 0;
  endtask

  task automatic cfg_wr(input logic [4:0] a, input logic [15:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 0;
  endtask

  task automatic bus(input logic [1:0] t, input logic [15:0] a, input logic [7:0] d);
    bus_valid = 1; bus_type = t; bus_addr = a; bus_data = d;
    tick();
    bus_valid = 0;
  endtask

  task automatic clr();
    seq_clear = 1;
    tick();
    seq_clear = 0;
  endtask

  task automatic set_level(input int k, input logic [15:0] av, input logic [15:0] am,
                           input logic [7:0] dv, input logic [7:0] dm,
                           input logic [1:0] kd, input logic [3:0] nd);
    cfg_wr(5'(k * 4 + 0), av);
    cfg_wr(5'(k * 4 + 1), am);
    cfg_wr(5'(k * 4 + 2), {dm, dv});
    cfg_wr(5'(k * 4 + 3), {10'd0, nd, kd});
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1: watchdog expired, actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_1234);
    idle_in();
    m_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1 reset halt", {15'd0, halt_req}, 16'd0);
    chk("R1 reset trig", {15'd0, trace_trig}, 16'd0);
    chk("R1 reset level", {14'd0, seq_level}, 16'd0);
    rst_n = 1;
    tick();

    // R2/R9: one level, write of 0x23 to 0x40
    cur_req = "R2";
    set_level(0, 16'h0040, 16'hFFFF, 8'h23, 8'hFF, 2'd1, 4'd0);
    cfg_wr(5'd16, 16'h0002);
    clr();
    bus(2'd1, 16'h0041, 8'h23); chk("R2 other address", {15'd0, halt_req}, 16'd0);
    bus(2'd0, 16'h0040, 8'h23); chk("R2 read not write", {15'd0, halt_req}, 16'd0);
    bus(2'd1, 16'h0040, 8'h24); chk("R2 other data", {15'd0, halt_req}, 16'd0);
    bus(2'd1, 16'h0040, 8'h23); chk("R2 exact write halts", {15'd0, halt_req}, 16'd1);
    cur_req = "R5";
    tick(); chk("R5 halt sticky", {15'd0, halt_req}, 16'd1);
    cur_req = "R1";
    clr(); chk("R1 clear drops halt", {15'd0, halt_req}, 16'd0);

    // R5: trace action
    cur_req = "R5";
    cfg_wr(5'd16, 16'h0003);
    clr();
    bus(2'd1, 16'h0040, 8'h23);
    chk("R5 trace pulse", {15'd0, trace_trig}, 16'd1);
    chk("R5 no halt on trace", {15'd0, halt_req}, 16'd0);
    tick(); chk("R5 pulse one cycle", {15'd0, trace_trig}, 16'd0);

    // R3: chain fetch 0x100 then read 0x23 from 0x80
    cur_req = "R3";
    set_level(0, 16'h0100, 16'hFFFF, 8'h00, 8'h00, 2'd2, 4'd0);
    set_level(1, 16'h0080, 16'hFFFF, 8'h23, 8'hFF, 2'd0, 4'd0);
    cfg_wr(5'd16, 16'h0006);
    clr();
    bus(2'd0, 16'h0080, 8'h23);
    chk("R3 later level ignored", {14'd0, seq_level}, 16'd0);
    chk("R3 no early halt", {15'd0, halt_req}, 16'd0);
    bus(2'd2, 16'h0100, 8'h00); chk("R3 advance", {14'd0, seq_level}, 16'd1);
    bus(2'd0, 16'h0080, 8'h23);
    chk("R3 chain halts", {15'd0, halt_req}, 16'd1);
    chk("R3 back to level 0", {14'd0, seq_level}, 16'd0);

    // R4: pass count 3
    cur_req = "R4";
    set_level(0, 16'h0100, 16'hFFFF, 8'h00, 8'h00, 2'd2, 4'd3);
    cfg_wr(5'd16, 16'h0002);
    clr();
    bus(2'd2, 16'h0100, 8'h00);
    bus(2'd0, 16'h0055, 8'h00);
    bus(2'd2, 16'h0100, 8'h00); chk("R4 two of three", {15'd0, halt_req}, 16'd0);
    bus(2'd2, 16'h0100, 8'h00); chk("R4 third halts", {15'd0, halt_req}, 16'd1);

    // R2: address mask, kind any
    cur_req = "R2";
    set_level(0, 16'h0100, 16'hFFF0, 8'h00, 8'h00, 2'd3, 4'd0);
    clr();
    bus(2'd0, 16'h0110, 8'h00); chk("R2 outside mask range", {15'd0, halt_req}, 16'd0);
    bus(2'd1, 16'h010F, 8'h77); chk("R2 inside mask range", {15'd0, halt_req}, 16'd1);

    // R8: sequencer disabled
    cur_req = "R8";
    cfg_wr(5'd16, 16'h0000);
    clr();
    bus(2'd0, 16'h0105, 8'h00);
    chk("R8 disabled no halt", {15'd0, halt_req}, 16'd0);
    chk("R8 disabled no move", {14'd0, seq_level}, 16'd0);

    // R6: execution breakpoint with retire qualifier
    cur_req = "R6";
    cfg_wr(5'd17, 16'h0200);
    cfg_wr(5'd16, 16'h0010);
    clr();
    bus(2'd2, 16'h0200, 8'h00); chk("R6 discarded fetch", {15'd0, halt_req}, 16'd0);
    exec_valid = 1; exec_addr = 16'h0201; tick();
    chk("R6 other retire", {15'd0, halt_req}, 16'd0);
    exec_addr = 16'h0200; tick(); exec_valid = 0;
    chk("R6 retire halts", {15'd0, halt_req}, 16'd1);

    // R7: hang detector, limit 5
    cur_req = "R7";
    cfg_wr(5'd18, 16'd5);
    cfg_wr(5'd16, 16'h0020);
    clr();
    bus_open = 1; repeat (5) tick(); bus_open = 0; tick();
    chk("R7 five open cycles", {15'd0, halt_req}, 16'd0);
    bus_open = 1; repeat (5) tick();
    chk("R7 still within limit", {15'd0, halt_req}, 16'd0);
    tick(); bus_open = 0;
    chk("R7 sixth open cycle halts", {15'd0, halt_req}, 16'd1);

    // random phase against the model
    cur_req = "R3";
    for (int c = 0; c < 20; c++) begin
      for (int k = 0; k < 4; k++)
        set_level(k, 16'h0010 + 16'($urandom % 4), ($urandom % 2) ? 16'hFFFF : 16'hFFFC,
                  8'(($urandom % 4) * 8'h11), ($urandom % 2) ? 8'hFF : 8'h0F,
                  2'($urandom % 4), 4'($urandom % 3));
      cfg_wr(5'd17, 16'h0010 + 16'($urandom % 4));
      cfg_wr(5'd18, 16'(3 + $urandom % 4));
      cfg_wr(5'd16, {10'd0, 1'($urandom % 2), 1'($urandom % 2),
                     2'($urandom % 4), 1'b1, 1'($urandom % 2)});
      clr();
      for (int i = 0; i < 300; i++) begin
        bus_valid  = ($urandom % 10) < 7;
        bus_type   = 2'($urandom % 3);
        bus_addr   = 16'h0010 + 16'($urandom % 4);
        bus_data   = 8'(($urandom % 4) * 8'h11);
        if (($urandom % 8) == 0) bus_open = ~bus_open;
        exec_valid = ($urandom % 6) == 0;
        exec_addr  = 16'h0010 + 16'($urandom % 4);
        seq_clear  = ($urandom % 40) == 0;
        tick();
      end
      idle_in();
      tick();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule